// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block arbitrates six interrupt sources for an 8-bit processor core: two external pins, three timer overflow flags and one serial port flag. Each source can be masked on its own, all of them can be masked together by a global enable, and each source is placed at one of two priority levels. When an unmasked source wins arbitration, the controller raises a request and presents the fixed service address of that source. The core answers with an acknowledge strobe when it issues the hardware call. It later sends a return strobe, which retires the level that is being serviced.

The external pins are sampled only on machine-cycle ticks. Each pin has its own select input that makes it level-sensitive or edge-sensitive. A level request is active while the pin is sampled low. An edge request is latched when the pin is sampled high on one tick and low on the next tick. Nesting is limited to one step: a high-level request may interrupt low-level service, and nothing else can preempt. On acknowledge, the controller clears only the flags that hardware is permitted to clear.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset, irq_req_o is 0, in_svc_o is 00 and flag_clr_o is 000000.
- R2: For an external source in level mode (select bit 0), the request flag takes the inverse of the pin on each mc_tick_i. Acknowledging that source does not clear the flag.
- R3: For an external source in edge mode (select bit 1), the flag is set when the pin is sampled 1 on one tick and 0 on the next tick. A pin that stays low does not set the flag again. The flag is cleared when that source is acknowledged.
- R4: A source takes part in arbitration only if its bit in src_en_i is 1 and glob_en_i is 1. While glob_en_i is 0, irq_req_o stays 0.
- R5: Source indices 0 to 5 are: ext0, timer0, ext1, timer1, serial, timer2. Within one priority level, the lowest pending index wins. irq_vec_o is 8*index+3, which gives 03h, 0Bh, 13h, 1Bh, 23h and 2Bh.
- R6: A pending source whose src_prio_i bit is 1 (high level) wins over every pending low-level source, whatever their indices. irq_hi_o shows the level of the request.
- R7: An acknowledge while a request is present sets the in-service bit of that level: in_svc_o[1] for high, in_svc_o[0] for low. While in_svc_o[1] is set, no request is raised. While only in_svc_o[0] is set, only high-level sources can request.
- R8: A reti_i strobe clears in_svc_o[1] if it is set, and otherwise clears in_svc_o[0].
- R9: During an acknowledged cycle, flag_clr_o pulses the bit of the winning source only when that source is timer0 (bit 1) or timer1 (bit 3). It never pulses for the serial flag or the timer2 flag.
- R10: An ack_i while no request is present changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mc_tick_i | input | 1 | Machine-cycle strobe; gates the sampling of the external pins |
| ext_pin_i | input | 2 | External interrupt pins, active low |
| ext_edge_i | input | 2 | Per-pin select: 1 means edge, 0 means level |
| tmr_flag_i | input | 3 | Timer overflow flags {timer2, timer1, timer0} |
| ser_flag_i | input | 1 | Serial port interrupt flag |
| glob_en_i | input | 1 | Global enable for all sources |
| src_en_i | input | 6 | Per-source enables, indexed by source |
| src_prio_i | input | 6 | Per-source priority, 1 means high |
| ack_i | input | 1 | Core has issued the hardware call |
| reti_i | input | 1 | Core has returned from service |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 8 | Service address of the winning source |
| irq_hi_o | output | 1 | The request is at the high level |
| in_svc_o | output | 2 | In-service bits {high, low} |
| flag_clr_o | output | 6 | Per-source hardware clear strobes |

## Verification
The assertions assume that ack_i comes only while a request is present, or while there is no request at all, and that reti_i comes only while some level is in service. The bench issues every ack and return strobe under these conditions. The assertions also assume that the timer and serial flags are levels owned by external logic. After a clear strobe, the bench drops the affected timer flag itself before it acknowledges again. External pins change only between ticks. Each stimulus is held for a full tick, so the sampled history that the edge check relies on matches the one the bench intended.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int N_SRC  = 6;
  localparam int N_EXT  = 2;
  localparam int IDX_W  = $clog2(N_SRC);
  localparam int VEC_W  = 8;
  localparam int VEC_BASE = 3;
  localparam int VEC_STEP = 8;

  // source indices in polling order
  localparam int SRC_EXT0 = 0;
  localparam int SRC_TMR0 = 1;
  localparam int SRC_EXT1 = 2;
  localparam int SRC_TMR1 = 3;
  localparam int SRC_SER  = 4;
  localparam int SRC_TMR2 = 5;

  // sources whose flags hardware may clear on acknowledge (timers 0/1)
  localparam logic [N_SRC-1:0] HW_CLR_MASK = N_SRC'(1 << SRC_TMR0) | N_SRC'(1 << SRC_TMR1);
endpackage

// File: rtl/irq_ext_sampler.sv
module irq_ext_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pin_i,
  input  logic edge_i,
  input  logic clr_i,
  output logic flag_o
);
  logic prev_q;
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      if (tick_i) prev_q <= pin_i;
      if (edge_i) begin
        // a new edge wins over a simultaneous clear
        if (tick_i && prev_q && !pin_i) flag_q <= 1'b1;
        else if (clr_i)                 flag_q <= 1'b0;
      end else if (tick_i) begin
        flag_q <= !pin_i;
      end
    end
  end

  assign flag_o = flag_q;

  assert_edge_needs_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && $past(edge_i) && $rose(flag_q)) |-> $past(tick_i));

  assert_level_follows_pin_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_i && tick_i) |=> (flag_q == !$past(pin_i)));
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] prio_i,
  input  logic             act_hi_i,
  input  logic             act_lo_i,
  output logic             req_o,
  output logic             hi_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N_SRC-1:0] hi_cand, lo_cand;
  logic [IDX_W-1:0] hi_idx, lo_idx;

  assign hi_cand = pend_i & prio_i;
  assign lo_cand = pend_i & ~prio_i;

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    hi_idx = '0;
    lo_idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (hi_cand[i]) hi_idx = IDX_W'(i);
      if (lo_cand[i]) lo_idx = IDX_W'(i);
    end
  end

  always_comb begin
    req_o = 1'b0;
    hi_o  = 1'b0;
    idx_o = '0;
    if (!act_hi_i) begin
      if (|hi_cand) begin
        req_o = 1'b1;
        hi_o  = 1'b1;
        idx_o = hi_idx;
      end else if (!act_lo_i && |lo_cand) begin
        req_o = 1'b1;
        idx_o = lo_idx;
      end
    end
  end

  assert_lo_svc_only_hi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && act_lo_i) |-> hi_o);

  assert_hi_beats_lo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !hi_o) |-> ((pend_i & prio_i) == '0));

  assert_winner_pending_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> pend_i[idx_o]);
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_hi_i,
  input  logic       set_lo_i,
  input  logic       reti_i,
  output logic [1:0] act_o
);
  logic [1:0] act_q, act_d;

  always_comb begin
    act_d = act_q;
    if (reti_i) begin
      if (act_q[1]) act_d[1] = 1'b0;
      else          act_d[0] = 1'b0;
    end
    if (set_hi_i) act_d[1] = 1'b1;
    if (set_lo_i) act_d[0] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 2'b00;
    else         act_q <= act_d;
  end

  assign act_o = act_q;

  assert_reti_clears_hi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && act_q[1] && !set_hi_i) |=> (!act_q[1] && (act_q[0] == $past(act_q[0] | set_lo_i))));

  assert_reti_clears_lo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !act_q[1] && !set_lo_i) |=> !act_q[0]);
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
  import irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mc_tick_i,
  input  logic [1:0]       ext_pin_i,
  input  logic [1:0]       ext_edge_i,
  input  logic [2:0]       tmr_flag_i,
  input  logic             ser_flag_i,
  input  logic             glob_en_i,
  input  logic [5:0]       src_en_i,
  input  logic [5:0]       src_prio_i,
  input  logic             ack_i,
  input  logic             reti_i,
  output logic             irq_req_o,
  output logic [7:0]       irq_vec_o,
  output logic             irq_hi_o,
  output logic [1:0]       in_svc_o,
  output logic [5:0]       flag_clr_o
);
  localparam int EXT_SRC [N_EXT] = '{SRC_EXT0, SRC_EXT1};

  logic [N_EXT-1:0] ext_flag;
  logic [N_EXT-1:0] ext_clr;
  logic [N_SRC-1:0] flags;
  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] win_oh;
  logic [IDX_W-1:0] win_idx;
  logic             sel_req, sel_hi, take;
  logic [1:0]       act;

  assign take   = ack_i && sel_req;
  assign win_oh = take ? N_SRC'(1 << win_idx) : '0;

  genvar g;
  generate
    for (g = 0; g < N_EXT; g++) begin : g_ext
      assign ext_clr[g] = win_oh[EXT_SRC[g]] && ext_edge_i[g];
      irq_ext_sampler u_smp (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (mc_tick_i),
        .pin_i  (ext_pin_i[g]),
        .edge_i (ext_edge_i[g]),
        .clr_i  (ext_clr[g]),
        .flag_o (ext_flag[g])
      );
    end
  endgenerate

  always_comb begin
    flags = '0;
    flags[SRC_EXT0] = ext_flag[0];
    flags[SRC_EXT1] = ext_flag[1];
    flags[SRC_TMR0] = tmr_flag_i[0];
    flags[SRC_TMR1] = tmr_flag_i[1];
    flags[SRC_TMR2] = tmr_flag_i[2];
    flags[SRC_SER]  = ser_flag_i;
  end

  assign pend = glob_en_i ? (flags & src_en_i) : '0;

  irq_prio_sel u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pend_i   (pend),
    .prio_i   (src_prio_i),
    .act_hi_i (act[1]),
    .act_lo_i (act[0]),
    .req_o    (sel_req),
    .hi_o     (sel_hi),
    .idx_o    (win_idx)
  );

  irq_level_track u_trk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_hi_i (take && sel_hi),
    .set_lo_i (take && !sel_hi),
    .reti_i   (reti_i),
    .act_o    (act)
  );

  assign irq_req_o  = sel_req;
  assign irq_hi_o   = sel_hi;
  assign irq_vec_o  = VEC_W'(VEC_BASE) + VEC_W'(win_idx) * VEC_W'(VEC_STEP);
  assign in_svc_o   = act;
  assign flag_clr_o = win_oh & HW_CLR_MASK;

  assert_glob_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glob_en_i |-> !irq_req_o);

  assert_hi_svc_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_svc_o[1] |-> !irq_req_o);

  assert_ack_enters_svc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_req_o && !reti_i) |=> (in_svc_o != 2'b00));

  assert_idle_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_req_o && !reti_i) |=> $stable(in_svc_o));

  assert_clr_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flag_clr_o) && (flag_clr_o == '0 || ack_i));
endmodule

// File: tb/nested_irq_ctrl_tb.sv
module nested_irq_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mc_tick_i = 1'b0;
  logic [1:0] ext_pin_i = 2'b11;
  logic [1:0] ext_edge_i = 2'b00;
  logic [2:0] tmr_flag_i = '0;
  logic       ser_flag_i = 1'b0;
  logic       glob_en_i = 1'b1;
  logic [5:0] src_en_i = 6'h3F;
  logic [5:0] src_prio_i = '0;
  logic       ack_i = 1'b0;
  logic       reti_i = 1'b0;
  logic       irq_req_o;
  logic [7:0] irq_vec_o;
  logic       irq_hi_o;
  logic [1:0] in_svc_o;
  logic [5:0] flag_clr_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  nested_irq_ctrl u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i) mc_tick_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i) mc_tick_i = 1'b0;
    #1;
  endtask

  task automatic do_ack(input logic [5:0] exp_clr, input string tag);
    @(negedge clk_i) ack_i = 1'b1;
    #1 chk(tag, 32'(flag_clr_o), 32'(exp_clr));
    @(posedge clk_i);
    @(negedge clk_i) ack_i = 1'b0;
    #1;
  endtask

  task automatic do_reti();
    @(negedge clk_i) reti_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i) reti_i = 1'b0;
    #1;
  endtask

  task automatic set_flags(input logic [5:0] f);
    tmr_flag_i = {f[5], f[3], f[1]};
    ser_flag_i = f[4];
  endtask

  // {flags[5:0], en[5:0], prio[5:0], glob, exp_req, exp_vec[7:0]}
  localparam int NV = 10;
  localparam logic [27:0] VT [NV] = '{
    {6'b000010, 6'h3F, 6'b000000, 1'b1, 1'b1, 8'h0B},
    {6'b111010, 6'h3F, 6'b000000, 1'b1, 1'b1, 8'h0B},
    {6'b111000, 6'h3F, 6'b000000, 1'b1, 1'b1, 8'h1B},
    {6'b110000, 6'h3F, 6'b000000, 1'b1, 1'b1, 8'h23},
    {6'b100000, 6'h3F, 6'b000000, 1'b1, 1'b1, 8'h2B},
    {6'b111010, 6'h3F, 6'b100000, 1'b1, 1'b1, 8'h2B},
    {6'b111010, 6'h3D, 6'b000000, 1'b1, 1'b1, 8'h1B},
    {6'b111010, 6'h3F, 6'b000000, 1'b0, 1'b0, 8'h00},
    {6'b111010, 6'h3F, 6'b011000, 1'b1, 1'b1, 8'h1B},
    {6'b000000, 6'h3F, 6'b000000, 1'b1, 1'b0, 8'h00}
  };

  initial begin
    #(200000 * 8);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1 req", 32'(irq_req_o), 0);
    chk("R1 in_svc", 32'(in_svc_o), 0);
    chk("R1 clr", 32'(flag_clr_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i) #1;

    // arbitration table: R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      set_flags(VT[i][27:22]);
      src_en_i   = VT[i][21:16];
      src_prio_i = VT[i][15:10];
      glob_en_i  = VT[i][9];
      #1;
      chk($sformatf("R5/R6/R4 vec%0d req", i), 32'(irq_req_o), 32'(VT[i][8]));
      if (VT[i][8]) chk($sformatf("R5/R6 vec%0d addr", i), 32'(irq_vec_o), 32'(VT[i][7:0]));
    end
    set_flags('0);
    src_en_i = 6'h3F; src_prio_i = '0; glob_en_i = 1'b1;
    #1;

    // R10: ack with nothing pending
    do_ack(6'b0, "R10 clr");
    chk("R10 in_svc", 32'(in_svc_o), 0);

    // R2: level-mode ext0
    ext_pin_i[0] = 1'b0;
    tick();
    chk("R2 req", 32'(irq_req_o), 1);
    chk("R2 vec", 32'(irq_vec_o), 32'h03);
    do_ack(6'b0, "R9 ext0 clr");
    chk("R7 in_svc lo", 32'(in_svc_o), 1);
    chk("R7 same level blocked", 32'(irq_req_o), 0);
    do_reti();
    chk("R8 lo retired", 32'(in_svc_o), 0);
    chk("R2 flag kept", 32'(irq_req_o), 1);
    ext_pin_i[0] = 1'b1;
    tick();
    chk("R2 follows pin", 32'(irq_req_o), 0);

    // R3: edge-mode ext1
    ext_edge_i[1] = 1'b1;
    ext_pin_i[1] = 1'b1;
    tick();
    chk("R3 no edge yet", 32'(irq_req_o), 0);
    ext_pin_i[1] = 1'b0;
    tick();
    chk("R3 edge req", 32'(irq_req_o), 1);
    chk("R3 edge vec", 32'(irq_vec_o), 32'h13);
    tick();
    chk("R3 latched", 32'(irq_req_o), 1);
    do_ack(6'b0, "R9 ext1 clr");
    do_reti();
    chk("R3 cleared by ack", 32'(irq_req_o), 0);
    tick();
    chk("R3 held low no retrigger", 32'(irq_req_o), 0);
    ext_pin_i[1] = 1'b1;
    tick();

    // R7 R8 R9: nesting
    set_flags(6'b001000);
    #1;
    chk("R5 tmr1 vec", 32'(irq_vec_o), 32'h1B);
    do_ack(6'b001000, "R9 tmr1 clr");
    set_flags(6'b000000);
    chk("R7 lo active", 32'(in_svc_o), 1);
    set_flags(6'b000010);
    #1;
    chk("R7 lo blocks lo", 32'(irq_req_o), 0);
    src_prio_i = 6'b100000;
    set_flags(6'b100010);
    #1;
    chk("R7 hi preempts", 32'(irq_req_o), 1);
    chk("R6 hi flag", 32'(irq_hi_o), 1);
    chk("R7 hi vec", 32'(irq_vec_o), 32'h2B);
    do_ack(6'b0, "R9 tmr2 never cleared");
    chk("R7 both active", 32'(in_svc_o), 3);
    src_prio_i = 6'b110000;
    set_flags(6'b110010);
    #1;
    chk("R7 hi blocks all", 32'(irq_req_o), 0);
    do_reti();
    chk("R8 hi retired first", 32'(in_svc_o), 1);
    chk("R5 ser before tmr2", 32'(irq_vec_o), 32'h23);
    chk("R7 hi again", 32'(irq_req_o), 1);
    do_ack(6'b0, "R9 ser never cleared");
    do_reti();
    chk("R8 hi retired", 32'(in_svc_o), 1);
    do_reti();
    chk("R8 lo retired", 32'(in_svc_o), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule